// File: doc/BRIEF.md
# Linked-List Tile Sample Gatherer

This block collects every sample of one spatial tile from external memory, where the tile's samples are held as a singly linked chain of nodes placed at arbitrary addresses. Each node begins with a two-word header (the address of the following node, then how many samples the node carries) and continues with the sample words themselves. All memory traffic leaves the block as burst read requests to a DMA-style port. The returned words come back on a simple valid/ready data channel.

Software-side control is a two-command interface. A configure command records the address of the tile's first node. A fetch command then walks the chain from that address. For every node the block reads the header, reads the node's samples as one burst, and streams them downstream in chain order over a valid/ready output that tolerates backpressure. The walk ends at a null next pointer, and the end is signalled by a single-cycle completion pulse. While a walk is in progress, further commands are held off.

Top module: `tile_list_fetch`

## Requirements
- R1: While reset is held and in the first cycle after it, `cmd_ready` is 1 and `rd_req_valid`, `smp_valid` and `tile_done` are 0.
- R2: A command with `cmd_op` = 0 (configure) stores `cmd_head` as the chain start and issues no memory request. No request is ever issued while the block is idle.
- R3: For each node at address A, the block requests 2 words at address A. Returned word 0 is the next-node address (its low address-width bits). Returned word 1 is the node's sample count.
- R4: A request is issued only after every word of the previous request has returned. An unaccepted request keeps its address and length stable.
- R5: For a node with sample count C > 0, the block requests C words at address A+2 and forwards them on `smp_data` in address order, across nodes in chain order. A stalled sample stays stable until `smp_ready`.
- R6: A sample count above NODE_CAP is treated as NODE_CAP. Only the first NODE_CAP sample words of that node are requested and emitted.
- R7: A node with sample count 0 causes no sample request and emits no sample, and the walk still continues at its next pointer.
- R8: A next pointer of 0 ends the walk. `tile_done` is then high for exactly one cycle, only after the last sample has been accepted downstream, and the block returns to idle.
- R9: A fetch command (`cmd_op` = 1) with a stored start address of 0 issues no request and raises `tile_done` in the cycle after the command is accepted.
- R10: `cmd_ready` is 0 from the cycle after a fetch command is accepted through the `tile_done` cycle. A command offered in that time waits and is accepted once the block is idle.
- R11: A second fetch without a new configure command walks the same chain again from the stored start address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted this cycle when high with cmd_valid |
| cmd_op | input | 1 | 0 = configure start address, 1 = fetch tile |
| cmd_head | input | AW | Chain start address for a configure command |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | DMA accepts the request |
| rd_req_addr | output | AW | Word address of the burst |
| rd_req_len | output | CW | Burst length in words |
| rd_data_valid | input | 1 | Returned word valid |
| rd_data_ready | output | 1 | Block takes the returned word |
| rd_data | input | DW | Returned word |
| smp_valid | output | 1 | Sample valid |
| smp_ready | input | 1 | Downstream accepts the sample |
| smp_data | output | DW | Sample word |
| tile_done | output | 1 | One-cycle pulse at the end of a walk |

## Verification
The embedded properties watch, on every cycle, the handshake rules: requests and samples held stable while stalled, burst lengths within 1..NODE_CAP, no null request address, command refusal while a request is pending, and a completion pulse that is one cycle wide and comes only with the output drained. The order of requests, the header/sample split, count clamping, skipping of empty nodes and the reuse of a stored start address depend on memory contents. Only the bench's behavioural chain model can show these, since it predicts each request and sample and compares them on every clock under varied ready patterns on all three channels.

// File: rtl/tlf_pkg.sv
package tlf_pkg;
  localparam logic OP_CONFIG = 1'b0;
  localparam logic OP_FETCH  = 1'b1;

  typedef enum logic [2:0] {
    WS_IDLE,
    WS_HDR_REQ,
    WS_HDR_NEXT,
    WS_HDR_CNT,
    WS_SMP_REQ,
    WS_SMP_DATA,
    WS_DRAIN,
    WS_DONE
  } walk_state_t;
endpackage

// File: rtl/tlf_cmd_regs.sv
module tlf_cmd_regs #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic          cmd_op,
  input  logic [AW-1:0] cmd_head,
  input  logic          accept_en,
  output logic          cmd_ready,
  output logic [AW-1:0] head_q,
  output logic          fetch_go
);
  import tlf_pkg::*;

  logic take;

  assign cmd_ready = accept_en;
  assign take      = cmd_valid && accept_en;
  assign fetch_go  = take && (cmd_op == OP_FETCH);

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
    end else if (take && (cmd_op == OP_CONFIG)) begin
      head_q <= cmd_head;
    end
  end
endmodule

// File: rtl/tlf_out_reg.sv
module tlf_out_reg #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic          holding,
  output logic          smp_valid,
  input  logic          smp_ready,
  output logic [DW-1:0] smp_data
);
  logic          v_q;
  logic [DW-1:0] d_q;

  assign in_ready  = !v_q || smp_ready;
  assign holding   = v_q;
  assign smp_valid = v_q;
  assign smp_data  = d_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= 1'b0;
      d_q <= '0;
    end else if (in_valid && in_ready) begin
      v_q <= 1'b1;
      d_q <= in_data;
    end else if (smp_ready) begin
      v_q <= 1'b0;
    end
  end

  // R5
  smp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && !smp_ready) |=> (smp_valid && $stable(smp_data)));
endmodule

// File: rtl/tlf_walker.sv
module tlf_walker #(
  parameter int AW       = 16,
  parameter int DW       = 32,
  parameter int NODE_CAP = 8,
  localparam int CW      = $clog2(NODE_CAP + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fetch_go,
  input  logic [AW-1:0] head,
  output logic          idle,
  output logic          rd_req_valid,
  input  logic          rd_req_ready,
  output logic [AW-1:0] rd_req_addr,
  output logic [CW-1:0] rd_req_len,
  input  logic          rd_data_valid,
  input  logic [DW-1:0] rd_data,
  output logic          rd_data_ready,
  output logic          push_valid,
  output logic [DW-1:0] push_data,
  input  logic          push_ready,
  input  logic          out_busy,
  output logic          tile_done
);
  import tlf_pkg::*;

  localparam logic [CW-1:0] HDR_LEN = CW'(2);
  localparam logic [CW-1:0] CAP_C   = CW'(NODE_CAP);

  function automatic logic [CW-1:0] clamp_cnt(input logic [DW-1:0] w);
    if (w > DW'(NODE_CAP)) return CAP_C;
    else                   return w[CW-1:0];
  endfunction

  walk_state_t   st;
  logic [AW-1:0] cur_q;
  logic [AW-1:0] next_q;
  logic [CW-1:0] rem_q;
  logic [AW-1:0] req_addr_q;
  logic [CW-1:0] req_len_q;
  logic [CW-1:0] cnt_now;

  assign cnt_now      = clamp_cnt(rd_data);
  assign idle         = (st == WS_IDLE);
  assign rd_req_valid = (st == WS_HDR_REQ) || (st == WS_SMP_REQ);
  assign rd_req_addr  = req_addr_q;
  assign rd_req_len   = req_len_q;
  assign tile_done    = (st == WS_DONE);
  assign push_valid   = (st == WS_SMP_DATA) && rd_data_valid;
  assign push_data    = rd_data;

  always_comb begin
    case (st)
      WS_HDR_NEXT, WS_HDR_CNT: rd_data_ready = 1'b1;
      WS_SMP_DATA:             rd_data_ready = push_ready;
      default:                 rd_data_ready = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= WS_IDLE;
      cur_q      <= '0;
      next_q     <= '0;
      rem_q      <= '0;
      req_addr_q <= '0;
      req_len_q  <= '0;
    end else begin
      case (st)
        WS_IDLE: begin
          if (fetch_go) begin
            if (head == '0) begin
              st <= WS_DONE;
            end else begin
              cur_q      <= head;
              req_addr_q <= head;
              req_len_q  <= HDR_LEN;
              st         <= WS_HDR_REQ;
            end
          end
        end
        WS_HDR_REQ: if (rd_req_ready) st <= WS_HDR_NEXT;
        WS_HDR_NEXT: begin
          if (rd_data_valid) begin
            next_q <= rd_data[AW-1:0];
            st     <= WS_HDR_CNT;
          end
        end
        WS_HDR_CNT: begin
          if (rd_data_valid) begin
            if (cnt_now != '0) begin
              rem_q      <= cnt_now;
              req_addr_q <= cur_q + AW'(2);
              req_len_q  <= cnt_now;
              st         <= WS_SMP_REQ;
            end else if (next_q == '0) begin
              st <= WS_DRAIN;
            end else begin
              cur_q      <= next_q;
              req_addr_q <= next_q;
              req_len_q  <= HDR_LEN;
              st         <= WS_HDR_REQ;
            end
          end
        end
        WS_SMP_REQ: if (rd_req_ready) st <= WS_SMP_DATA;
        WS_SMP_DATA: begin
          if (rd_data_valid && push_ready) begin
            rem_q <= rem_q - CW'(1);
            if (rem_q == CW'(1)) begin
              if (next_q == '0) begin
                st <= WS_DRAIN;
              end else begin
                cur_q      <= next_q;
                req_addr_q <= next_q;
                req_len_q  <= HDR_LEN;
                st         <= WS_HDR_REQ;
              end
            end
          end
        end
        WS_DRAIN: if (!out_busy) st <= WS_DONE;
        WS_DONE:  st <= WS_IDLE;
        default:  st <= WS_IDLE;
      endcase
    end
  end

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req_valid && !rd_req_ready) |=>
      (rd_req_valid && $stable(rd_req_addr) && $stable(rd_req_len)));

  // R6
  req_len_range_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req_valid |-> ((rd_req_len != '0) && (rd_req_len <= CAP_C)));

  // R3
  req_addr_nonnull_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req_valid |-> (rd_req_addr != '0));

  // R8
  done_drained_chk: assert property (@(posedge clk) disable iff (rst)
    tile_done |-> !out_busy);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    tile_done |=> !tile_done);
endmodule

// File: rtl/tile_list_fetch.sv
module tile_list_fetch #(
  parameter int AW       = 16,
  parameter int DW       = 32,
  parameter int NODE_CAP = 8,
  localparam int CW      = $clog2(NODE_CAP + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_op,
  input  logic [AW-1:0] cmd_head,
  output logic          rd_req_valid,
  input  logic          rd_req_ready,
  output logic [AW-1:0] rd_req_addr,
  output logic [CW-1:0] rd_req_len,
  input  logic          rd_data_valid,
  output logic          rd_data_ready,
  input  logic [DW-1:0] rd_data,
  output logic          smp_valid,
  input  logic          smp_ready,
  output logic [DW-1:0] smp_data,
  output logic          tile_done
);
  logic          w_idle;
  logic [AW-1:0] w_head;
  logic          w_go;
  logic          p_valid;
  logic [DW-1:0] p_data;
  logic          p_ready;
  logic          o_busy;

  tlf_cmd_regs #(.AW(AW)) u_cmd (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_head(cmd_head),
    .accept_en(w_idle), .cmd_ready(cmd_ready),
    .head_q(w_head), .fetch_go(w_go)
  );

  tlf_walker #(.AW(AW), .DW(DW), .NODE_CAP(NODE_CAP)) u_walk (
    .clk(clk), .rst(rst),
    .fetch_go(w_go), .head(w_head), .idle(w_idle),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_addr(rd_req_addr), .rd_req_len(rd_req_len),
    .rd_data_valid(rd_data_valid), .rd_data(rd_data),
    .rd_data_ready(rd_data_ready),
    .push_valid(p_valid), .push_data(p_data), .push_ready(p_ready),
    .out_busy(o_busy), .tile_done(tile_done)
  );

  tlf_out_reg #(.DW(DW)) u_out (
    .clk(clk), .rst(rst),
    .in_valid(p_valid), .in_data(p_data), .in_ready(p_ready),
    .holding(o_busy),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data)
  );

  // R10
  busy_refuse_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req_valid |-> !cmd_ready);
endmodule

// File: tb/test_tile_list_fetch.sv
module test_tile_list_fetch;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 16;
  localparam int DW  = 32;
  localparam int CAP = 8;
  localparam int CW  = $clog2(CAP + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic          cmd_op = 1'b0;
  logic [AW-1:0] cmd_head = '0;
  logic          rd_req_valid;
  logic          rd_req_ready = 1'b0;
  logic [AW-1:0] rd_req_addr;
  logic [CW-1:0] rd_req_len;
  logic          rd_data_valid = 1'b0;
  logic          rd_data_ready;
  logic [DW-1:0] rd_data = '0;
  logic          smp_valid;
  logic          smp_ready = 1'b0;
  logic [DW-1:0] smp_data;
  logic          tile_done;

  tile_list_fetch #(.AW(AW), .DW(DW), .NODE_CAP(CAP)) i_tile_list_fetch (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_head(cmd_head),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_addr(rd_req_addr), .rd_req_len(rd_req_len),
    .rd_data_valid(rd_data_valid), .rd_data_ready(rd_data_ready), .rd_data(rd_data),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data),
    .tile_done(tile_done)
  );

  logic [31:0] mem [0:255];
  int n_chk = 0;
  int n_bad = 0;
  int p_req = 100, p_data = 100, p_smp = 100;
  int exp_addr[$];
  int exp_len[$];
  logic [31:0] exp_smp[$];
  logic [31:0] pend[$];
  int head_model = 0;
  bit busy = 0;
  bit done_flag = 0;
  bit run_mon = 0;
  int got = 0, nreq = 0, since_load = 0, done_lat = 0;
  bit cmd_pending = 0;
  logic cmd_op_w = 1'b0;
  logic [AW-1:0] cmd_head_w = '0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic void build(input int h);
    int a = h;
    int guard = 0;
    while (a != 0 && guard < 64) begin
      int n, c;
      exp_addr.push_back(a);
      exp_len.push_back(2);
      n = int'(mem[a + 1]);
      c = (n > CAP) ? CAP : n;
      if (c > 0) begin
        exp_addr.push_back(a + 2);
        exp_len.push_back(c);
        for (int k = 0; k < c; k++) exp_smp.push_back(mem[a + 2 + k]);
      end
      a = int'(mem[a][15:0]);
      guard++;
    end
  endfunction

  // behavioural model and memory responder, compared every clock
  initial begin
    forever begin
      @(negedge clk);
      if (run_mon) begin
        cmd_valid     = cmd_pending;
        cmd_op        = cmd_op_w;
        cmd_head      = cmd_head_w;
        rd_req_ready  = (int'($urandom_range(99, 0)) < p_req);
        rd_data_valid = (pend.size() > 0) && (int'($urandom_range(99, 0)) < p_data);
        rd_data       = rd_data_valid ? pend[0] : '0;
        smp_ready     = (int'($urandom_range(99, 0)) < p_smp);
        #1;
        if (busy) since_load++;
        chk(cmd_ready == !busy, "R10 cmd_ready", cmd_ready, !busy);
        if (!busy) chk(!rd_req_valid, "R2 idle request", rd_req_valid, 0);
        if (tile_done) begin
          chk(busy, "R8 done while idle", busy, 1);
          chk(exp_smp.size() == 0 && exp_addr.size() == 0, "R8 done early",
              exp_smp.size() + exp_addr.size(), 0);
          busy = 0;
          done_flag = 1;
          done_lat = since_load;
        end
        if (rd_req_valid && rd_req_ready) begin
          nreq++;
          chk(pend.size() == 0, "R4 words outstanding", pend.size(), 0);
          if (exp_addr.size() == 0) begin
            chk(0, "R3 unexpected request", rd_req_addr, 0);
          end else begin
            chk(int'(rd_req_addr) == exp_addr[0], (exp_len[0] == 2) ? "R3 addr" : "R5 addr",
                rd_req_addr, exp_addr[0]);
            chk(int'(rd_req_len) == exp_len[0], (exp_len[0] == 2) ? "R3 len" : "R5 len",
                rd_req_len, exp_len[0]);
            void'(exp_addr.pop_front());
            void'(exp_len.pop_front());
          end
          for (int k = 0; k < int'(rd_req_len); k++) pend.push_back(mem[int'(rd_req_addr) + k]);
        end
        if (rd_data_valid && rd_data_ready) void'(pend.pop_front());
        if (smp_valid && smp_ready) begin
          got++;
          if (exp_smp.size() == 0) chk(0, "R5 unexpected sample", smp_data, 0);
          else begin
            chk(smp_data == exp_smp[0], "R5 sample", smp_data, exp_smp[0]);
            void'(exp_smp.pop_front());
          end
        end
        if (cmd_valid && cmd_ready) begin
          cmd_pending = 0;
          if (cmd_op == 1'b1) begin
            build(head_model);
            busy = 1; since_load = 0; got = 0; nreq = 0; done_flag = 0;
          end else begin
            head_model = int'(cmd_head);
          end
        end
      end
    end
  end

  task automatic do_cmd(input logic op, input int h);
    cmd_op_w = op;
    cmd_head_w = AW'(h);
    cmd_pending = 1;
    while (cmd_pending) @(posedge clk);
  endtask

  task automatic wait_done();
    while (!done_flag) @(posedge clk);
    repeat (2) @(posedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R8 act=0 exp=1");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    // chain A: 0x10 (3 samples) -> 0x40 (empty) -> 0x60 (8 samples) -> end
    mem[16'h10] = 32'h40; mem[16'h11] = 3;
    for (int k = 0; k < 3; k++) mem[16'h12 + k] = 32'hA000 + k;
    mem[16'h40] = 32'h60; mem[16'h41] = 0;
    mem[16'h60] = 32'h0;  mem[16'h61] = 8;
    for (int k = 0; k < 8; k++) mem[16'h62 + k] = 32'hB000 + k;
    // chain B: one node with an oversized count
    mem[16'h80] = 32'h0; mem[16'h81] = 20;
    for (int k = 0; k < 20; k++) mem[16'h82 + k] = 32'hC000 + k;

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1 cmd_ready", cmd_ready, 1);
    chk(!rd_req_valid, "R1 rd_req_valid", rd_req_valid, 0);
    chk(!smp_valid, "R1 smp_valid", smp_valid, 0);
    chk(!tile_done, "R1 tile_done", tile_done, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(cmd_ready && !rd_req_valid && !smp_valid && !tile_done, "R1 after reset", 0, 1);
    run_mon = 1;

    // R2 R3 R5 R7: configure then fetch, full-rate channels
    do_cmd(1'b0, 16'h10);
    repeat (4) @(posedge clk);
    do_cmd(1'b1, 0);
    wait_done();
    chk(got == 11, "R7 sample total", got, 11);
    chk(nreq == 5, "R7 request total", nreq, 5);

    // R11: refetch with random stalls on every channel
    p_req = 50; p_data = 60; p_smp = 40;
    do_cmd(1'b1, 0);
    wait_done();
    chk(got == 11, "R11 refetch samples", got, 11);

    // R6: oversized count
    do_cmd(1'b0, 16'h80);
    do_cmd(1'b1, 0);
    wait_done();
    chk(got == CAP, "R6 clamped samples", got, CAP);
    chk(nreq == 2, "R6 requests", nreq, 2);

    // R9: null start address
    p_req = 100; p_data = 100; p_smp = 100;
    do_cmd(1'b0, 0);
    do_cmd(1'b1, 0);
    wait_done();
    chk(done_lat == 1, "R9 done latency", done_lat, 1);
    chk(nreq == 0, "R9 no requests", nreq, 0);
    chk(got == 0, "R9 no samples", got, 0);

    // R10: command offered during a walk waits for idle
    p_smp = 30;
    do_cmd(1'b0, 16'h10);
    do_cmd(1'b1, 0);
    do_cmd(1'b0, 16'h80);
    chk(done_flag == 1'b1, "R10 held until done", done_flag, 1);
    p_smp = 100;
    do_cmd(1'b1, 0);
    wait_done();
    chk(got == CAP, "R10 new head used", got, CAP);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule